// File: doc/BRIEF.md
# Link Transaction Error Monitor

This block follows every transaction on a chip-to-chip serial link from the moment the command goes out until the target's acknowledge phase ends. It looks for three kinds of fault. The first is an acknowledge that never arrives within a programmable window. The second is a pair of parity bits returned by the target that disagree with the locally computed pair. The third is an error bit raised by the target during the acknowledge. Each fault sets a global error flag and a specific cause flag, and both stay set. A parity fault also stores the two received parity bits.

While the global error flag is set, the block asks the surrounding link logic to freeze its address and data buffers and to send an IDLE command in place of every transaction. Software reads the flags, then clears them by writing ones. If the faulted transaction was the read half of a read-modify-write, or was a posted write with another transaction already queued behind it, the follow-on transaction is cancelled. This is reported with a one-cycle cancel pulse and a sticky cancel flag. The error interrupt is gated by an interrupt enable input.

The control is a three-state machine:
- IDLE: no transaction is open.
- WAIT_ACK: a command has been sent and the timeout counter is running.
- ERR_HOLD: a fault was recorded and the link is held quiet.

It has these transitions:
- start: IDLE to WAIT_ACK, taken on `xfer_start` while enabled.
- ack_ok: WAIT_ACK to IDLE, a clean acknowledge.
- abort: WAIT_ACK to IDLE, taken when `enable` drops.
- fault: WAIT_ACK to ERR_HOLD, taken on any of the three faults.
- release: ERR_HOLD to IDLE, taken when software clears the global error flag.

Top module: `lem_link_err_mon`

## Requirements
- R1: If no acknowledge is seen within N waiting cycles, the global error flag and the timeout flag become 1 right after the clock edge that ends the N-th waiting cycle. N is `tmo_cfg`, and the first waiting cycle is the cycle after the edge that samples `xfer_start`.
- R2: A `tmo_cfg` of zero gives a window of 2^TW waiting cycles.
- R3: On an acknowledge where `rx_par` differs from `exp_par`, the global error flag and the parity flag are set, and `par_cap` takes the value of `rx_par`.
- R4: On an acknowledge with `tgt_err` high, the global error flag and the target-error flag are set.
- R5: When a parity mismatch and a target error arrive in the same acknowledge cycle, both specific flags are set together.
- R6: While the global error flag is 1, `force_idle` and `buf_freeze` are 1 and `xfer_start` opens no transaction. When the flag is 0, both outputs are 0.
- R7: A fault on a transaction of kind 2'b01 (read-modify-write read), or of kind 2'b10 (posted write) with `next_pending` high at the fault, sets the cancel flag and pulses `cancel_next` for one cycle. Kind 2'b00 never cancels.
- R8: Flags are cleared by writing 1 with `clr_wr`. The `clr_mask` bits are [0] global error, [1] timeout, [2] parity, [3] target error and [4] cancel. A flag whose bit is 0 keeps its value. Clearing the global error flag releases IDLE substitution and the buffer freeze.
- R9: `err_irq` equals the global error flag ANDed with `irq_en`.
- R10: Reset clears all flags, `par_cap` and any open transaction at once. While `enable` is low, `xfer_start` is ignored, and an open transaction is dropped without recording a fault.
- R11: An acknowledge that arrives in the last cycle of the window is accepted, and no timeout is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Monitor enable |
| irq_en | input | 1 | Interrupt enable |
| xfer_start | input | 1 | Command sent on the link |
| xfer_kind | input | 2 | 00 plain, 01 read-modify-write read, 10 posted write |
| next_pending | input | 1 | Another transaction already queued |
| ack_valid | input | 1 | Final acknowledge cycle |
| rx_par | input | 2 | Parity bits returned by the target |
| exp_par | input | 2 | Locally computed parity |
| tgt_err | input | 1 | Target error signal |
| tmo_cfg | input | TW | Timeout window in cycles, 0 means 2^TW |
| clr_wr | input | 1 | Flag clear strobe |
| clr_mask | input | 5 | Write-1-to-clear mask |
| err_flag | output | 1 | Global error flag |
| tmo_flag | output | 1 | Timeout flag |
| par_flag | output | 1 | Parity flag |
| terr_flag | output | 1 | Target-error flag |
| cncl_flag | output | 1 | Transaction-cancelled flag |
| par_cap | output | 2 | Captured received parity |
| err_irq | output | 1 | Error interrupt |
| buf_freeze | output | 1 | Freeze address and data buffers |
| force_idle | output | 1 | Replace transactions by IDLE |
| cancel_next | output | 1 | One-cycle cancel pulse |

## Verification
Two pairs of events can land in the same cycle. First, an acknowledge can arrive in exactly the cycle where the timeout window expires. The bench provokes this by placing the acknowledge on the last allowed waiting cycle and requires that no flag is set afterwards. Second, a parity mismatch and a target error can arrive in one acknowledge cycle. The bench drives both together and requires both specific flags, the captured parity and the interrupt to appear after the same edge. A behavioural model in the bench predicts every output and is compared with the design on every clock.

// File: rtl/lem_pkg.sv
package lem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_ACK = 2'd1,
        ST_ERR_HOLD = 2'd2
    } lem_state_e;

    typedef enum logic [1:0] {
        KIND_PLAIN  = 2'b00,
        KIND_RMW_RD = 2'b01,
        KIND_POSTED = 2'b10,
        KIND_RSVD   = 2'b11
    } lem_kind_e;

    localparam int NFLAG  = 5;
    localparam int F_ERR  = 0;
    localparam int F_TMO  = 1;
    localparam int F_PAR  = 2;
    localparam int F_TERR = 3;
    localparam int F_CNCL = 4;

endpackage

// File: rtl/lem_timer.sv
module lem_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic [TW-1:0] tmo_cfg,
    output logic          expire
);
    localparam int CW = TW + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] limit;

    // zero selects the widest window
    always_comb begin
        limit   = (tmo_cfg == '0) ? (CW'(1) << TW) : {1'b0, tmo_cfg};
        cnt_inc = cnt_q + CW'(1);
        expire  = run && (cnt_inc == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_inc;
        end
    end
endmodule

// File: rtl/lem_fault_dec.sv
module lem_fault_dec
    import lem_pkg::*;
(
    input  logic             active,
    input  logic             ack_valid,
    input  logic [1:0]       rx_par,
    input  logic [1:0]       exp_par,
    input  logic             tgt_err,
    input  logic             expire,
    input  lem_kind_e        kind,
    input  logic             next_pending,
    output logic [NFLAG-1:0] set_vec
);
    logic par_bad, terr_hit, tmo_hit, any_hit, cancel_hit;

    always_comb begin
        par_bad    = active && ack_valid && (rx_par != exp_par);
        terr_hit   = active && ack_valid && tgt_err;
        // an acknowledge in the last window cycle wins over expiry
        tmo_hit    = active && !ack_valid && expire;
        any_hit    = par_bad || terr_hit || tmo_hit;
        cancel_hit = any_hit && ((kind == KIND_RMW_RD) ||
                                 ((kind == KIND_POSTED) && next_pending));
        set_vec         = '0;
        set_vec[F_ERR]  = any_hit;
        set_vec[F_TMO]  = tmo_hit;
        set_vec[F_PAR]  = par_bad;
        set_vec[F_TERR] = terr_hit;
        set_vec[F_CNCL] = cancel_hit;
    end
endmodule

// File: rtl/lem_flags.sv
module lem_flags
    import lem_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_vec,
    input  logic [NFLAG-1:0] clr_vec,
    input  logic [1:0]       rx_par,
    output logic [NFLAG-1:0] flags,
    output logic [1:0]       par_cap
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags   <= '0;
            par_cap <= '0;
        end else begin
            flags <= (flags & ~clr_vec) | set_vec;
            if (set_vec[F_PAR]) begin
                par_cap <= rx_par;
            end
        end
    end
endmodule

// File: rtl/lem_link_err_mon.sv
module lem_link_err_mon
    import lem_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          irq_en,
    input  logic          xfer_start,
    input  logic [1:0]    xfer_kind,
    input  logic          next_pending,
    input  logic          ack_valid,
    input  logic [1:0]    rx_par,
    input  logic [1:0]    exp_par,
    input  logic          tgt_err,
    input  logic [TW-1:0] tmo_cfg,
    input  logic          clr_wr,
    input  logic [4:0]    clr_mask,
    output logic          err_flag,
    output logic          tmo_flag,
    output logic          par_flag,
    output logic          terr_flag,
    output logic          cncl_flag,
    output logic [1:0]    par_cap,
    output logic          err_irq,
    output logic          buf_freeze,
    output logic          force_idle,
    output logic          cancel_next
);
    lem_state_e       state_q, state_d;
    lem_kind_e        kind_q;
    logic             active, expire, any_fault, release_hit;
    logic [NFLAG-1:0] set_vec, clr_vec, flags;
    logic             cancel_q;

    assign active      = (state_q == ST_WAIT_ACK) && enable;
    assign clr_vec     = clr_wr ? clr_mask : '0;
    assign release_hit = clr_vec[F_ERR];
    assign any_fault   = set_vec[F_ERR];

    lem_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state_q != ST_WAIT_ACK),
        .run     (active),
        .tmo_cfg (tmo_cfg),
        .expire  (expire)
    );

    lem_fault_dec u_dec (
        .active       (active),
        .ack_valid    (ack_valid),
        .rx_par       (rx_par),
        .exp_par      (exp_par),
        .tgt_err      (tgt_err),
        .expire       (expire),
        .kind         (kind_q),
        .next_pending (next_pending),
        .set_vec      (set_vec)
    );

    lem_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .rx_par  (rx_par),
        .flags   (flags),
        .par_cap (par_cap)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (enable && xfer_start) state_d = ST_WAIT_ACK;
            ST_WAIT_ACK: begin
                if (!enable)        state_d = ST_IDLE;
                else if (any_fault) state_d = ST_ERR_HOLD;
                else if (ack_valid) state_d = ST_IDLE;
            end
            ST_ERR_HOLD: if (release_hit) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            kind_q   <= KIND_PLAIN;
            cancel_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            cancel_q <= set_vec[F_CNCL];
            if (state_q == ST_IDLE && enable && xfer_start) begin
                kind_q <= lem_kind_e'(xfer_kind);
            end
        end
    end

    // outputs
    always_comb begin
        force_idle = 1'b0;
        buf_freeze = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_WAIT_ACK: ;
            ST_ERR_HOLD: begin
                force_idle = 1'b1;
                buf_freeze = 1'b1;
            end
            default: ;
        endcase
        err_flag    = flags[F_ERR];
        tmo_flag    = flags[F_TMO];
        par_flag    = flags[F_PAR];
        terr_flag   = flags[F_TERR];
        cncl_flag   = flags[F_CNCL];
        err_irq     = flags[F_ERR] && irq_en;
        cancel_next = cancel_q;
    end
endmodule

// File: rtl/lem_chk.sv
module lem_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_en,
    input logic       clr_wr,
    input logic [4:0] clr_mask,
    input logic       err_flag,
    input logic       tmo_flag,
    input logic       par_flag,
    input logic       terr_flag,
    input logic       cncl_flag,
    input logic       err_irq,
    input logic       buf_freeze,
    input logic       force_idle,
    input logic       cancel_next
);
    assert_hold_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (force_idle && buf_freeze));
    assert_quiet_needs_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (force_idle || buf_freeze) |-> err_flag);
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !err_irq);
    assert_irq_raised_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && irq_en) |-> err_irq);
    assert_cancel_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_next |-> cncl_flag);
    assert_cancel_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_next |=> !cancel_next);
    assert_tmo_global_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> err_flag);
    assert_par_global_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_flag) |-> err_flag);
    assert_terr_global_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(terr_flag) |-> err_flag);
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !(clr_wr && clr_mask[0])) |=> err_flag);
endmodule

bind lem_link_err_mon lem_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_en      (irq_en),
    .clr_wr      (clr_wr),
    .clr_mask    (clr_mask),
    .err_flag    (err_flag),
    .tmo_flag    (tmo_flag),
    .par_flag    (par_flag),
    .terr_flag   (terr_flag),
    .cncl_flag   (cncl_flag),
    .err_irq     (err_irq),
    .buf_freeze  (buf_freeze),
    .force_idle  (force_idle),
    .cancel_next (cancel_next)
);

// File: tb/lem_link_err_mon_tb.sv
module lem_link_err_mon_tb;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0, irq_en = 1'b0, xfer_start = 1'b0;
    logic [1:0]    xfer_kind = 2'b00;
    logic          next_pending = 1'b0, ack_valid = 1'b0, tgt_err = 1'b0;
    logic [1:0]    rx_par = 2'b00, exp_par = 2'b00;
    logic [TW-1:0] tmo_cfg = '0;
    logic          clr_wr = 1'b0;
    logic [4:0]    clr_mask = 5'b0;
    logic          err_flag, tmo_flag, par_flag, terr_flag, cncl_flag;
    logic [1:0]    par_cap;
    logic          err_irq, buf_freeze, force_idle, cancel_next;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    lem_link_err_mon #(.TW(TW)) u_dut (.*);

    // behavioural reference model
    bit m_err, m_tmo, m_par, m_terr, m_cncl, m_cancel, m_busy;
    int m_cap, m_wait, m_kind;

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_err, m_tmo, m_par, m_terr, m_cncl, m_cancel, m_busy} = '0;
            m_cap = 0; m_wait = 0; m_kind = 0;
        end else begin
            bit was_err, fault, f_par, f_terr, f_tmo;
            int lim;
            was_err = m_err;
            fault = 0; f_par = 0; f_terr = 0; f_tmo = 0;
            lim = (tmo_cfg == 0) ? (1 << TW) : int'(tmo_cfg);
            if (clr_wr) begin
                if (clr_mask[0]) m_err  = 0;
                if (clr_mask[1]) m_tmo  = 0;
                if (clr_mask[2]) m_par  = 0;
                if (clr_mask[3]) m_terr = 0;
                if (clr_mask[4]) m_cncl = 0;
            end
            m_cancel = 0;
            if (!enable) begin
                m_busy = 0;
            end else if (m_busy) begin
                m_wait = m_wait + 1;
                if (ack_valid) begin
                    f_par  = (rx_par != exp_par);
                    f_terr = tgt_err;
                    m_busy = 0;
                end else if (m_wait == lim) begin
                    f_tmo  = 1;
                    m_busy = 0;
                end
                fault = f_par || f_terr || f_tmo;
                if (fault) begin
                    m_err = 1;
                    if (f_par)  begin m_par = 1; m_cap = int'(rx_par); end
                    if (f_terr) m_terr = 1;
                    if (f_tmo)  m_tmo  = 1;
                    if (m_kind == 1 || (m_kind == 2 && next_pending)) begin
                        m_cncl = 1; m_cancel = 1;
                    end
                end
            end else if (xfer_start && !was_err) begin
                m_busy = 1; m_wait = 0; m_kind = int'(xfer_kind);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (!done) begin
            check(tmo_flag == m_tmo,   "R1 tmo_flag", tmo_flag, m_tmo);
            check(par_flag == m_par,   "R3 par_flag", par_flag, m_par);
            check(int'(par_cap) == m_cap, "R3 par_cap", par_cap, m_cap);
            check(terr_flag == m_terr, "R4 terr_flag", terr_flag, m_terr);
            check(force_idle == m_err && buf_freeze == m_err, "R6 quiet",
                  {force_idle, buf_freeze}, {m_err, m_err});
            check(cncl_flag == m_cncl && cancel_next == m_cancel, "R7 cancel",
                  {cncl_flag, cancel_next}, {m_cncl, m_cancel});
            check(err_flag == m_err,   "R8 err_flag", err_flag, m_err);
            check(err_irq == (m_err && irq_en), "R9 err_irq", err_irq, m_err && irq_en);
        end
    end

    task automatic send(input logic [1:0] kind, input bit np);
        xfer_start = 1; xfer_kind = kind; next_pending = np;
        @(negedge clk);
        xfer_start = 0;
    endtask

    task automatic ack_at(input int k, input logic [1:0] rx, input logic [1:0] ex, input bit te);
        repeat (k - 1) @(negedge clk);
        ack_valid = 1; rx_par = rx; exp_par = ex; tgt_err = te;
        @(negedge clk);
        ack_valid = 0; tgt_err = 0;
    endtask

    task automatic clear(input logic [4:0] m);
        clr_wr = 1; clr_mask = m;
        @(negedge clk);
        clr_wr = 0; clr_mask = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(err_flag == 0 && par_cap == 0 && force_idle == 0, "R10 reset", err_flag, 0);
        rst_n = 1; enable = 1; tmo_cfg = 4'd5;
        @(negedge clk);

        // clean transaction
        send(2'b00, 0);
        ack_at(3, 2'b01, 2'b01, 0);
        @(negedge clk);
        check(err_flag == 0, "R11 clean ack", err_flag, 0);

        // R1: timeout after 5 cycles
        send(2'b00, 0);
        repeat (4) @(negedge clk);
        check(tmo_flag == 0, "R1 before window end", tmo_flag, 0);
        @(negedge clk);
        check(tmo_flag == 1 && err_flag == 1, "R1 timeout", tmo_flag, 1);
        // R6: start ignored while held
        send(2'b01, 0);
        repeat (8) @(negedge clk);
        check(cncl_flag == 0 && force_idle == 1, "R6 start ignored", cncl_flag, 0);
        // R8: partial clear keeps global flag
        clear(5'b00010);
        check(tmo_flag == 0 && err_flag == 1, "R8 partial clear", err_flag, 1);
        clear(5'b00001);
        check(err_flag == 0 && force_idle == 0, "R8 release", force_idle, 0);

        // R2: zero means 16 cycles
        tmo_cfg = '0;
        send(2'b00, 0);
        repeat (15) @(negedge clk);
        check(err_flag == 0, "R2 before 16", err_flag, 0);
        @(negedge clk);
        check(tmo_flag == 1, "R2 at 16", tmo_flag, 1);
        clear(5'b11111);

        // R11: ack in final window cycle
        tmo_cfg = 4'd4;
        send(2'b00, 0);
        ack_at(4, 2'b11, 2'b11, 0);
        @(negedge clk);
        check(err_flag == 0 && tmo_flag == 0, "R11 last-cycle ack", err_flag, 0);

        // R3/R7: parity on rmw read
        send(2'b01, 0);
        ack_at(2, 2'b10, 2'b01, 0);
        check(par_flag == 1 && par_cap == 2'b10, "R3 parity capture", par_cap, 2);
        check(cancel_next == 1 && cncl_flag == 1, "R7 rmw cancel", cancel_next, 1);
        clear(5'b11111);

        // R5/R9: both faults, posted without follower
        irq_en = 1;
        send(2'b10, 0);
        ack_at(1, 2'b00, 2'b11, 1);
        check(par_flag && terr_flag && par_cap == 2'b00, "R5 joint faults", {par_flag, terr_flag}, 3);
        check(cncl_flag == 0, "R7 posted no follower", cncl_flag, 0);
        check(err_irq == 1, "R9 irq enabled", err_irq, 1);
        irq_en = 0;
        @(negedge clk);
        check(err_irq == 0, "R9 irq gated", err_irq, 0);
        clear(5'b11111);

        // R4/R7: target error, posted with follower
        send(2'b10, 1);
        ack_at(2, 2'b01, 2'b01, 1);
        check(terr_flag == 1 && par_flag == 0, "R4 target error", terr_flag, 1);
        check(cncl_flag == 1, "R7 posted with follower", cncl_flag, 1);
        next_pending = 0;
        clear(5'b11111);

        // R7: plain kind never cancels
        send(2'b00, 1);
        ack_at(1, 2'b00, 2'b00, 1);
        check(cncl_flag == 0, "R7 plain", cncl_flag, 0);
        next_pending = 0;
        clear(5'b11111);

        // R10: disabled start ignored, abort on disable
        enable = 0;
        send(2'b00, 0);
        repeat (6) @(negedge clk);
        check(err_flag == 0, "R10 disabled start", err_flag, 0);
        enable = 1;
        send(2'b00, 0);
        enable = 0;
        repeat (6) @(negedge clk);
        check(tmo_flag == 0, "R10 abort", tmo_flag, 0);
        enable = 1;

        // R10: reset mid-transaction
        send(2'b01, 0);
        rst_n = 0;
        @(negedge clk);
        check(err_flag == 0 && cncl_flag == 0, "R10 reset mid", err_flag, 0);
        rst_n = 1;
        repeat (8) @(negedge clk);
        check(err_flag == 0, "R10 no stale timeout", err_flag, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule